// File: doc/BRIEF.md
# Programmable 16-bit Interval Timer Channel

This block is one 16-bit timer channel with three word-addressed registers: the running count, a control word and a compare value. On every tick the count moves up by one. A tick comes from the system clock, from a divide-by-eight prescaler, or from an external horizontal-sync strobe, depending on the channel variant and the control bits. The count either runs through the full 16-bit range or returns to zero when it reaches the compare value.

Each time the count reaches the compare value or the all-ones value, the channel latches a sticky status bit. It can also emit a one-cycle interrupt pulse. The pulse fires either on every qualifying event or only on the first one after the control word is written. Software clears the sticky bits by reading the control word.

A parameter fixes the channel variant: a plain channel, a line-rate channel that can count sync strobes, or a divider channel that has the prescaler and a stop bit. Control bits that have no function on a variant, and the reserved control bits, are stored and read back unchanged.

Top module: `prog_timer`

## Requirements
- R1: After reset the count, the control word and the compare value read as 0 and `irq` is low. Register select codes: 0 selects the count, 1 the control word, 2 the compare value.
- R2: A write to the count loads the low 16 bits of `wr_data`. A value above 0xFFFF is truncated.
- R3: When the count reaches 0xFFFF, control bit 12 is set. On the next tick the count wraps to 0.
- R4: When control bit 3 is set, the tick that would make the count equal to the compare value loads 0 instead. When bit 3 is clear, the count takes the compare value and keeps going.
- R5: Control bit 4 enables an interrupt when the count reaches the compare value, and bit 5 enables one when it reaches 0xFFFF. `irq` is high for exactly one cycle per interrupting tick. If both events fall on one tick, only one pulse is produced.
- R6: When control bit 6 is set, every enabled event pulses `irq`. When it is clear, only the first enabled event after a control write pulses `irq`.
- R7: Reaching the compare value sets control bit 11. Each of the two events sets bit 10. Bits 11 and 12 stay set until the control word is read.
- R8: A read of the control word (`rd_en` with select 1) returns the current value. It then clears bits 11 and 12 and leaves all other bits unchanged.
- R9: A write to the control word resets the count to 0, clears bits 11 and 12, re-arms the one-shot interrupt, and stores every other bit as written, reserved bits included.
- R10: A write to the compare value leaves the count unchanged.
- R11: On the divider variant, control bit 9 makes the count advance once every 8 clocks, timed from the control write. Control bit 0 stops the count.
- R12: On the line-rate variant, control bit 8 makes the count advance once per cycle in which `hsync_strobe` is high. On the other variants bit 8 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 count, 1 control, 2 compare |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; clears the status bits when the control word is selected |
| wr_data | input | 32 | Write data; only the low 16 bits are kept |
| hsync_strobe | input | 1 | External line-rate tick, one cycle wide |
| rd_data | output | 16 | Value of the selected register |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A fault in the count arithmetic shows on the count port within the very next tick. After many ticks the error has also built up in the read value, so sweeping several compare values catches off-by-one wrap points. A lost or stuck one-shot arm bit shows as one interrupt pulse too many or too few within a few compare periods. A wrong prescaler phase moves the first divided tick away from the eighth clock after the control write. A status bit that fails to clear on a read shows on the very next read of the control word.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

    localparam int CNT_W = 16;
    localparam int BUS_W = 32;

    localparam int KIND_PLAIN = 0;
    localparam int KIND_LINE  = 1;
    localparam int KIND_DIV   = 2;

    localparam logic [1:0] SEL_COUNT  = 2'd0;
    localparam logic [1:0] SEL_CTRL   = 2'd1;
    localparam logic [1:0] SEL_TARGET = 2'd2;

    localparam int CB_HALT     = 0;
    localparam int CB_WRAP_TGT = 3;
    localparam int CB_IE_TGT   = 4;
    localparam int CB_IE_MAX   = 5;
    localparam int CB_REPEAT   = 6;
    localparam int CB_EXT_SRC  = 8;
    localparam int CB_SLOW     = 9;
    localparam int CB_ANY_EV   = 10;
    localparam int CB_HIT_TGT  = 11;
    localparam int CB_HIT_MAX  = 12;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] ctrl;
        logic [CNT_W-1:0] target;
        logic             armed;
        logic             irq;
    } tmr_state_t;

endpackage

// File: rtl/prog_timer_tick.sv
module prog_timer_tick
    import prog_timer_pkg::*;
#(
    parameter int KIND = KIND_PLAIN,
    parameter int DIV  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel_ext,
    input  logic sel_slow,
    input  logic halt,
    input  logic ext_strobe,
    output logic tick
);
    localparam int  PW      = (DIV > 2) ? $clog2(DIV) : 1;
    localparam bit  HAS_DIV = (KIND == KIND_DIV);
    localparam bit  HAS_EXT = (KIND == KIND_LINE);

    logic [PW-1:0] pre_d, pre_q;
    logic          pre_wrap;
    logic          stopped;
    logic          use_slow;

    assign stopped  = HAS_DIV && halt;
    assign use_slow = HAS_DIV && sel_slow;
    assign pre_wrap = (pre_q == PW'(DIV - 1));

    always_comb begin
        pre_d = pre_q;
        if (restart) begin
            pre_d = '0;
        end else if (use_slow && !stopped) begin
            pre_d = pre_wrap ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    always_comb begin
        if (stopped)                  tick = 1'b0;
        else if (use_slow)            tick = pre_wrap;
        else if (HAS_EXT && sel_ext)  tick = ext_strobe;
        else                          tick = 1'b1;
    end

endmodule

// File: rtl/prog_timer_step.sv
module prog_timer_step
    import prog_timer_pkg::*;
(
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] target,
    input  logic             wrap_at_target,
    output logic [CNT_W-1:0] count_nxt,
    output logic             ev_tgt,
    output logic             ev_max
);
    logic [CNT_W-1:0] inc;

    always_comb begin
        inc       = count + 1'b1;
        ev_tgt    = tick && (inc == target);
        ev_max    = tick && (inc == CNT_MAX);
        count_nxt = (ev_tgt && wrap_at_target) ? '0 : inc;
    end

endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import prog_timer_pkg::*;
#(
    parameter int KIND = KIND_PLAIN,
    parameter int DIV  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             hsync_strobe,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    tmr_state_t       st_d, st_q;
    logic             tick;
    logic [CNT_W-1:0] count_nxt;
    logic             ev_tgt, ev_max;
    logic             ctrl_wr, ctrl_rd, cnt_wr, tgt_wr;
    logic             want_irq;

    assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);
    assign ctrl_rd = rd_en && (reg_sel == SEL_CTRL);
    assign cnt_wr  = wr_en && (reg_sel == SEL_COUNT);
    assign tgt_wr  = wr_en && (reg_sel == SEL_TARGET);

    prog_timer_tick #(.KIND(KIND), .DIV(DIV)) i_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (ctrl_wr),
        .sel_ext   (st_q.ctrl[CB_EXT_SRC]),
        .sel_slow  (st_q.ctrl[CB_SLOW]),
        .halt      (st_q.ctrl[CB_HALT]),
        .ext_strobe(hsync_strobe),
        .tick      (tick)
    );

    prog_timer_step i_step (
        .tick          (tick),
        .count         (st_q.count),
        .target        (st_q.target),
        .wrap_at_target(st_q.ctrl[CB_WRAP_TGT]),
        .count_nxt     (count_nxt),
        .ev_tgt        (ev_tgt),
        .ev_max        (ev_max)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (tick) st_d.count = count_nxt;

        if (ctrl_rd) begin
            st_d.ctrl[CB_HIT_TGT] = 1'b0;
            st_d.ctrl[CB_HIT_MAX] = 1'b0;
        end
        if (ev_tgt) begin
            st_d.ctrl[CB_HIT_TGT] = 1'b1;
            st_d.ctrl[CB_ANY_EV]  = 1'b1;
        end
        if (ev_max) begin
            st_d.ctrl[CB_HIT_MAX] = 1'b1;
            st_d.ctrl[CB_ANY_EV]  = 1'b1;
        end

        want_irq = (ev_tgt && st_q.ctrl[CB_IE_TGT]) ||
                   (ev_max && st_q.ctrl[CB_IE_MAX]);
        if (want_irq && (st_q.ctrl[CB_REPEAT] || st_q.armed)) begin
            st_d.irq   = 1'b1;
            st_d.armed = 1'b0;
        end

        if (cnt_wr) st_d.count  = wr_data[CNT_W-1:0];
        if (tgt_wr) st_d.target = wr_data[CNT_W-1:0];
        if (ctrl_wr) begin
            st_d.ctrl             = wr_data[CNT_W-1:0];
            st_d.ctrl[CB_HIT_TGT] = 1'b0;
            st_d.ctrl[CB_HIT_MAX] = 1'b0;
            st_d.count            = '0;
            st_d.armed            = 1'b1;
            st_d.irq              = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_COUNT:  rd_data = st_q.count;
            SEL_CTRL:   rd_data = st_q.ctrl;
            SEL_TARGET: rd_data = st_q.target;
            default:    rd_data = '0;
        endcase
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk
    import prog_timer_pkg::*;
#(
    parameter int KIND = KIND_PLAIN
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_sel,
    input logic             wr_en,
    input logic             rd_en,
    input logic [BUS_W-1:0] wr_data,
    input logic             tick,
    input tmr_state_t       st_q,
    input logic             irq
);
    localparam bit IS_DIV = (KIND == KIND_DIV);

    // R2
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_COUNT) |=> st_q.count == $past(wr_data[CNT_W-1:0]));

    // R5
    irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st_q.ctrl[CB_IE_TGT] || st_q.ctrl[CB_IE_MAX]));

    // R7
    sticky_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[CB_HIT_TGT] && !(rd_en && reg_sel == SEL_CTRL) && !(wr_en && reg_sel == SEL_CTRL))
        |=> st_q.ctrl[CB_HIT_TGT]);

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == SEL_CTRL && !wr_en && !tick)
        |=> (!st_q.ctrl[CB_HIT_TGT] && !st_q.ctrl[CB_HIT_MAX]));

    // R9
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_CTRL)
        |=> (st_q.count == '0 && st_q.armed && !st_q.ctrl[CB_HIT_TGT] && !st_q.ctrl[CB_HIT_MAX]));

    // R10
    target_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_TARGET && !tick) |=> $stable(st_q.count));

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_DIV && st_q.ctrl[CB_HALT] && !wr_en) |=> $stable(st_q.count));

endmodule

bind prog_timer prog_timer_chk #(.KIND(KIND)) i_prog_timer_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .reg_sel(reg_sel),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wr_data(wr_data),
    .tick   (tick),
    .st_q   (st_q),
    .irq    (irq)
);

// File: tb/test_prog_timer.sv
module test_prog_timer;
    import prog_timer_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       reg_sel = SEL_COUNT;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [BUS_W-1:0] wr_data = '0;
    logic             hsync_strobe = 1'b0;
    logic [CNT_W-1:0] rd_div, rd_line;
    logic             irq_div, irq_line;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prog_timer #(.KIND(KIND_DIV), .DIV(8)) i_prog_timer (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .hsync_strobe(hsync_strobe), .rd_data(rd_div), .irq(irq_div)
    );

    prog_timer #(.KIND(KIND_LINE), .DIV(8)) i_prog_timer_line (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .hsync_strobe(hsync_strobe), .rd_data(rd_line), .irq(irq_line)
    );

    always @(negedge clk) if (irq_div) irq_seen++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [BUS_W-1:0] val);
        @(negedge clk);
        reg_sel = sel; wr_data = val; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [CNT_W-1:0] v);
        reg_sel = sel;
        #1;
        v = rd_div;
    endtask

    task automatic rd_ctrl(output logic [CNT_W-1:0] v);
        @(negedge clk);
        reg_sel = SEL_CTRL; rd_en = 1'b1;
        #1;
        v = rd_div;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20) @(posedge clk);
        wait_cycles(200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] v;
        wait_cycles(3);
        // R1 reset state
        peek(SEL_COUNT, v);  check("R1 count", v, 0);
        peek(SEL_CTRL, v);   check("R1 ctrl", v, 0);
        peek(SEL_TARGET, v); check("R1 target", v, 0);
        check("R1 irq", irq_div, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 truncation and free count
        wr(SEL_CTRL, 32'h0);
        wr(SEL_COUNT, 32'h0001_2345);
        wait_cycles(5);
        peek(SEL_COUNT, v); check("R2 truncated load", v, 16'h234A);

        // R3 overflow reach and wrap, bit 5 interrupt
        wr(SEL_TARGET, 32'h8000);
        wr(SEL_CTRL, 32'h0020);
        wr(SEL_COUNT, 32'hFFFA);
        irq_seen = 0;
        wait_cycles(7);
        peek(SEL_COUNT, v); check("R3 wrap to zero", v, 1);
        check("R5 overflow irq", irq_seen, 1);
        rd_ctrl(v); check("R7 overflow status", v, 16'h1420);
        rd_ctrl(v); check("R8 cleared after read", v, 16'h0420);

        // R4 target wrap with repeat, R6 repeat sweep
        wr(SEL_TARGET, 32'd10);
        wr(SEL_CTRL, 32'h0058);
        wait_cycles(12);
        rd_ctrl(v); check("R7 target status", v, 16'h0C58);
        rd_ctrl(v); check("R8 target cleared", v, 16'h0458);
        for (int t = 1; t <= 12; t++) begin
            wr(SEL_TARGET, t);
            wr(SEL_CTRL, 32'h0058);
            irq_seen = 0;
            wait_cycles(3 * t + 1);
            peek(SEL_COUNT, v); check("R4 wrap count", v, (3 * t + 1) % t);
            check("R6 repeat pulses", irq_seen, (3 * t + 1) / t);
        end

        // R6 one-shot and re-arm
        wr(SEL_TARGET, 32'd5);
        wr(SEL_CTRL, 32'h0018);
        irq_seen = 0;
        wait_cycles(23);
        check("R6 one-shot", irq_seen, 1);
        wr(SEL_CTRL, 32'h0018);
        irq_seen = 0;
        wait_cycles(7);
        check("R6 re-armed", irq_seen, 1);

        // R4 no wrap: count passes target
        wr(SEL_TARGET, 32'd4);
        wr(SEL_CTRL, 32'h0010);
        irq_seen = 0;
        wait_cycles(6);
        peek(SEL_COUNT, v); check("R4 pass target", v, 6);
        check("R5 target irq", irq_seen, 1);

        // R5 simultaneous target and overflow: single pulse
        wr(SEL_TARGET, 32'hFFFF);
        wr(SEL_CTRL, 32'h0078);
        wr(SEL_COUNT, 32'hFFFD);
        irq_seen = 0;
        wait_cycles(4);
        peek(SEL_COUNT, v); check("R5 both events count", v, 2);
        check("R5 single pulse", irq_seen, 1);
        rd_ctrl(v); check("R7 both flags", v, 16'h1C78);

        // R11 halt, R10 target write keeps count
        wr(SEL_CTRL, 32'h0001);
        wr(SEL_COUNT, 32'h55);
        wait_cycles(10);
        peek(SEL_COUNT, v); check("R11 halted", v, 16'h55);
        wr(SEL_TARGET, 32'h1234);
        peek(SEL_COUNT, v); check("R10 count kept", v, 16'h55);
        peek(SEL_TARGET, v); check("R10 target stored", v, 16'h1234);

        // R9 reserved bits stored
        wr(SEL_CTRL, 32'hE086);
        rd_ctrl(v); check("R9 reserved bits", v, 16'hE086);

        // R11 divide by eight
        wr(SEL_CTRL, 32'h0200);
        wait_cycles(80);
        peek(SEL_COUNT, v); check("R11 div count 80", v, 10);
        wait_cycles(7);
        peek(SEL_COUNT, v); check("R11 div count 87", v, 10);
        wait_cycles(1);
        peek(SEL_COUNT, v); check("R11 div count 88", v, 11);

        // R12 external strobe on line channel, ignored on divider channel
        wr(SEL_CTRL, 32'h0100);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            hsync_strobe = (i % 7 == 3);
        end
        @(negedge clk);
        hsync_strobe = 1'b0;
        #1;
        reg_sel = SEL_COUNT;
        #1;
        check("R12 line strobes", rd_line, 7);
        check("R12 divider ignores bit 8", rd_div, 51);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule